// File: doc/BRIEF.md
# PCM Serial Transmit Port

This block places one 8-bit companded voice sample per frame onto a serial line that other devices also drive. An external bit clock and an external transmit frame sync set the timing. Both are sampled by a much faster system clock, so the block works with a continuous bit clock or with a short burst of pulses around each frame.

Software or an upstream stage hands over the byte to send through a valid/ready port. The port never stalls: `s_ready` is high whenever the block is out of reset, and each accepted byte replaces the one held before. When a frame begins, the held byte is taken into a shift register, optionally with A-law alternate-bit inversion. The bits then leave most significant bit first, and the output enable is raised only for the block's own eight-bit slot.

If the frame sync stops changing for too long, the transmitter goes to sleep and keeps its line released. The next sync transition wakes it.

Top module: `pcm_tx_port`

## Requirements
- R1: After reset `tx_oe` is 0 and `s_ready` is 1.
- R2: Once a slot has begun, `tx_d` carries the word most significant bit first. It advances by exactly one bit on each later rising edge of `bclk_i`, and holds between those edges.
- R3: If `fsync_i` is already high when `bclk_i` rises, the first bit is launched from that rising edge.
- R4: If `fsync_i` rises while `bclk_i` is high, the first bit is launched from the sync edge itself, and the second bit follows on the next rising edge of `bclk_i`.
- R5: `tx_oe` is 1 only from the first bit launch until the falling edge of `bclk_i` that follows the launch of the eighth bit. At all other times it is 0. Nine bit-clock pulses around a frame are enough, and the line is released even if the bit clock then stops.
- R6: When `alaw_i` is 1 (A-law), the word sent is the held byte XOR 0x55, which inverts bits 6, 4, 2 and 0. For example, a held 0xFF goes out as 10101010 and a held 0x00 goes out as 01010101. When `alaw_i` is 0 (mu-law), the byte goes out unchanged, for example 0x80 as 10000000. The mode is sampled at the start of the slot.
- R7: A byte is accepted in any cycle in which `s_valid` and `s_ready` are both high. A slot sends the byte held when the slot starts. A byte accepted in the very cycle of the start is used by the next slot. With no new byte, the previous one is sent again.
- R8: If `fsync_i` shows no transition for `PD_LIMIT` system clocks, the port sleeps. While asleep, `tx_oe` is 0 and any slot in progress is abandoned. The next sync transition ends the sleep.
- R9: Only one slot starts per high period of `fsync_i`. Holding the sync high across more bit-clock edges does not start another slot until the sync has been seen low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Transmit bit clock (continuous or burst) |
| fsync_i | input | 1 | Transmit frame sync |
| alaw_i | input | 1 | 1 selects A-law bit inversion, 0 selects mu-law |
| s_data | input | WORD_W | Byte to send |
| s_valid | input | 1 | `s_data` is offered |
| s_ready | output | 1 | Byte accepted when high together with `s_valid` |
| tx_d | output | 1 | Serial data towards the line driver |
| tx_oe | output | 1 | Line driver enable; high impedance when 0 |

## Verification
A new byte can arrive in the same system-clock cycle in which a slot starts. The bench provokes this by counting the two-stage sampling latency of the bit clock and raising `s_valid` exactly in the start cycle. It then judges the outcome by decoding two frames: the first must carry the older byte and the second the newer one. The bench also aligns a sync rise with a high bit clock, so that a slot starts from the sync edge, and checks that the next rising edge produces the second bit rather than a repeated first bit.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

  typedef enum logic {
    LAW_MU = 1'b0,
    LAW_A  = 1'b1
  } law_e;

  // Alternate-bit mask starting at bit 0 (0x55 for an 8-bit word)
  function automatic logic [31:0] alt_mask(input int w);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < w; i += 2) m[i] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= {q[STAGES-1:0], din};
  end

  assign lvl  = q[STAGES-1];
  assign rise = q[STAGES-1] & ~q[STAGES];
  assign fall = ~q[STAGES-1] & q[STAGES];
endmodule

// File: rtl/pcm_sleep_watch.sv
module pcm_sleep_watch #(
  parameter int LIMIT = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic activity,
  output logic sleep
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] idle_cnt;
  logic          pd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      pd_q     <= 1'b0;
    end else if (activity) begin
      idle_cnt <= '0;
      pd_q     <= 1'b0;
    end else if (idle_cnt == CW'(LIMIT)) begin
      pd_q <= 1'b1;
    end else begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  assign sleep = pd_q & ~activity;
endmodule

// File: rtl/pcm_slot_shifter.sv
module pcm_slot_shifter #(
  parameter int WORD_W = 8,
  parameter int CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              b_lvl,
  input  logic              b_rise,
  input  logic              b_fall,
  input  logic              fs_lvl,
  input  logic              fs_rise,
  input  logic              sleep,
  input  logic [WORD_W-1:0] word,
  output logic              start,
  output logic              tx_d,
  output logic              tx_oe,
  output logic [CNT_W-1:0]  bit_cnt
);
  logic [WORD_W-1:0] sh_q;
  logic              act_q;
  logic              armed_q;

  assign start = armed_q & ~sleep & ((fs_rise & b_lvl) | (b_rise & fs_lvl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      act_q   <= 1'b0;
      armed_q <= 1'b0;
      tx_d    <= 1'b0;
      tx_oe   <= 1'b0;
      bit_cnt <= '0;
    end else begin
      if (!fs_lvl) armed_q <= 1'b1;
      if (sleep) begin
        act_q <= 1'b0;
        tx_oe <= 1'b0;
      end else if (start) begin
        sh_q    <= word << 1;
        tx_d    <= word[WORD_W-1];
        bit_cnt <= CNT_W'(1);
        act_q   <= 1'b1;
        tx_oe   <= 1'b1;
        armed_q <= 1'b0;
      end else if (act_q && b_rise && bit_cnt < CNT_W'(WORD_W)) begin
        tx_d    <= sh_q[WORD_W-1];
        sh_q    <= sh_q << 1;
        bit_cnt <= bit_cnt + 1'b1;
      end else if (act_q && b_fall && bit_cnt == CNT_W'(WORD_W)) begin
        act_q <= 1'b0;
        tx_oe <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pcm_tx_port.sv
module pcm_tx_port
  import pcm_tx_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PD_LIMIT    = 65536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_i,
  input  logic              fsync_i,
  input  logic              alaw_i,
  input  logic [WORD_W-1:0] s_data,
  input  logic              s_valid,
  output logic              s_ready,
  output logic              tx_d,
  output logic              tx_oe
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [WORD_W-1:0] ALT_MASK = WORD_W'(alt_mask(WORD_W));

  logic [1:0] raw_in, lvl, rise, fall;
  assign raw_in = {fsync_i, bclk_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    pcm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_in[g]),
      .lvl  (lvl[g]),
      .rise (rise[g]),
      .fall (fall[g])
    );
  end

  logic b_lvl, b_rise, b_fall, fs_lvl, fs_rise, fs_chg;
  assign b_lvl   = lvl[0];
  assign b_rise  = rise[0];
  assign b_fall  = fall[0];
  assign fs_lvl  = lvl[1];
  assign fs_rise = rise[1];
  assign fs_chg  = rise[1] | fall[1];

  logic sleep;
  pcm_sleep_watch #(.LIMIT(PD_LIMIT)) u_watch (
    .clk     (clk),
    .rst_n   (rst_n),
    .activity(fs_chg),
    .sleep   (sleep)
  );

  // holding register: never stalls, newest byte wins
  logic [WORD_W-1:0] hold_q;
  assign s_ready = rst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hold_q <= '0;
    else if (s_valid && s_ready) hold_q <= s_data;
  end

  law_e law;
  logic [WORD_W-1:0] word;
  assign law  = law_e'(alaw_i);
  assign word = (law == LAW_A) ? (hold_q ^ ALT_MASK) : hold_q;

  logic             start;
  logic [CNT_W-1:0] bit_cnt;
  pcm_slot_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .b_lvl  (b_lvl),
    .b_rise (b_rise),
    .b_fall (b_fall),
    .fs_lvl (fs_lvl),
    .fs_rise(fs_rise),
    .sleep  (sleep),
    .word   (word),
    .start  (start),
    .tx_d   (tx_d),
    .tx_oe  (tx_oe),
    .bit_cnt(bit_cnt)
  );
endmodule

// File: rtl/pcm_tx_port_chk.sv
module pcm_tx_port_chk #(
  parameter int WORD_W = 8,
  parameter int CNT_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_d,
  input logic             tx_oe,
  input logic             start,
  input logic             b_rise,
  input logic             b_fall,
  input logic             sleep,
  input logic [CNT_W-1:0] bit_cnt
);
  // R3/R4: the enable only rises from a slot start
  p_oe_from_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_oe) |-> $past(start));

  // R2: data holds unless a bit edge or a start happened
  p_hold_between_edges_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_oe && $past(tx_oe) && !$past(b_rise) && !$past(start)) |-> $stable(tx_d));

  // R5: release only on a bit-clock falling edge or through sleep
  p_release_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_oe) |-> ($past(b_fall) || $past(sleep)));

  // R8: sleeping keeps the line released
  p_sleep_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sleep) |-> !tx_oe);

  // R2: never more than one word of bits
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(WORD_W));
endmodule

bind pcm_tx_port pcm_tx_port_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tx_d   (tx_d),
  .tx_oe  (tx_oe),
  .start  (start),
  .b_rise (b_rise),
  .b_fall (b_fall),
  .sleep  (sleep),
  .bit_cnt(bit_cnt)
);

// File: tb/pcm_tx_port_tb.sv
module pcm_tx_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, fsync = 1'b0, alaw = 1'b0, s_valid = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic s_ready, tx_d, tx_oe;
  int checks = 0, fails = 0;
  logic [7:0] held = 8'h00;

  always #5 clk = ~clk;

  pcm_tx_port #(.PD_LIMIT(600)) u_dut (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fsync_i(fsync), .alaw_i(alaw),
    .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready), .tx_d(tx_d), .tx_oe(tx_oe)
  );

  function automatic logic [7:0] exp_word(input logic [7:0] b, input logic a);
    return a ? (b ^ 8'h55) : b;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] b);
    s_valid = 1'b1; s_data = b;
    @(negedge clk);
    s_valid = 1'b0;
    held = b;
  endtask

  // one bit-clock period: 8 clk high, 8 clk low; sample at the end of the high phase
  task automatic bit_period(input int set_hi, input int set_lo, input int clr_lo,
                            input int ld_at, input logic [7:0] ld_b,
                            output logic oe_s, output logic d_s);
    bclk = 1'b1;
    for (int h = 0; h < 8; h++) begin
      if (h == set_hi) fsync = 1'b1;
      if (h == ld_at) begin s_valid = 1'b1; s_data = ld_b; end
      if (h == ld_at + 1) s_valid = 1'b0;
      @(negedge clk);
    end
    oe_s = tx_oe; d_s = tx_d;
    bclk = 1'b0;
    for (int h = 0; h < 8; h++) begin
      if (h == set_lo) fsync = 1'b1;
      if (h == clr_lo) fsync = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic run_frame(input bit lag, input bit long_sync, input bit collide,
                           input logic [7:0] cbyte, input int n_after, input string tag);
    logic [7:0] got, exp;
    logic o, dd;
    bit oe_bad;
    got = '0; oe_bad = 0;
    exp = exp_word(held, alaw);
    for (int p = -2; p < 8 + n_after; p++) begin
      int sh, sl, cl, la;
      sh = -1; sl = -1; cl = -1; la = -1;
      if (p == -1 && !lag) sl = 4;
      if (p == 0 && lag) sh = 2;
      if (p == 0 && !long_sync) cl = 4;
      if (p == 9 && long_sync) cl = 4;
      if (p == 0 && collide) la = 2;
      bit_period(sh, sl, cl, la, cbyte, o, dd);
      if (p >= 0 && p < 8) begin
        got[7-p] = dd;
        if (o !== 1'b1) oe_bad = 1;
      end else if (o !== 1'b0) oe_bad = 1;
    end
    if (collide) held = cbyte;
    chk(got === exp, tag, got, exp);
    chk(!oe_bad, {"R5 slot enable ", tag}, {7'd0, oe_bad}, 8'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic o, dd;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(tx_oe === 1'b0, "R1 oe in reset", {7'd0, tx_oe}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(s_ready === 1'b1, "R1 ready after reset", {7'd0, s_ready}, 8'd1);
    chk(tx_oe === 1'b0, "R1 oe after reset", {7'd0, tx_oe}, 8'd0);

    // directed corners
    alaw = 1'b0; load(8'h80); run_frame(0, 0, 0, 8'h00, 2, "R2 R3 R6 mu-law 0x80");
    alaw = 1'b1; load(8'hFF); run_frame(0, 0, 0, 8'h00, 2, "R6 A-law full scale");
    alaw = 1'b1; load(8'h00); run_frame(1, 0, 0, 8'h00, 2, "R4 R6 lag start A-law");
    alaw = 1'b0; run_frame(1, 0, 0, 8'h00, 2, "R4 R7 repeat without load");
    alaw = 1'b0; load(8'h3C); run_frame(0, 0, 1, 8'hC3, 2, "R7 load in start cycle keeps old");
    run_frame(0, 0, 0, 8'h00, 2, "R7 collided byte sent next");
    load(8'h96); run_frame(0, 1, 0, 8'h00, 2, "R9 long sync one slot");
    alaw = 1'b1; load(8'h5A); run_frame(0, 0, 0, 8'h00, 0, "R5 burst clock");
    repeat (12) @(negedge clk);
    chk(tx_oe === 1'b0, "R5 released after burst", {7'd0, tx_oe}, 8'd0);

    // stuck sync: slot stalls with clock stopped, then sleep releases it
    alaw = 1'b0; load(8'hE1);
    bit_period(-1, 4, -1, -1, 8'h00, o, dd);
    bit_period(-1, -1, 4, -1, 8'h00, o, dd);
    for (int p = 1; p < 4; p++) bit_period(-1, -1, -1, -1, 8'h00, o, dd);
    repeat (300) @(negedge clk);
    chk(tx_oe === 1'b1, "R8 no early sleep", {7'd0, tx_oe}, 8'd1);
    repeat (400) @(negedge clk);
    chk(tx_oe === 1'b0, "R8 sleep releases line", {7'd0, tx_oe}, 8'd0);
    load(8'h4B); run_frame(0, 0, 0, 8'h00, 2, "R8 wake on sync edge");

    // constrained random frames
    for (int i = 0; i < 20; i++) begin
      alaw = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 3) != 0) load(8'($urandom_range(0, 255)));
      run_frame(1'($urandom_range(0, 1)), 0, 0, 8'h00, 2, "R2 R6 R7 random frame");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule